// File: doc/BRIEF.md
# PHY Management Frame Interpreter

This block stands in for a single PHY behind a management port. Software writes a 32-bit management frame word, and the block decodes it in place against a built-in file of thirty-two 16-bit PHY registers. It carries out the read or write the frame asks for and stores the resulting frame word with its completion flag already set. The word can then be read back on the next cycle. No serial management signalling is produced. The whole exchange is resolved inside one clock.

The register file models the side effects that drivers depend on:
- The reset and negotiation-restart bits of the control register clear themselves.
- A restart completes negotiation at once.
- The link-status bit in the status register tracks a link input.
- The partner 100BASE-TX full-duplex bit also tracks the link input.

A change on the link input raises a 16-bit event word for a neighbouring interrupt block. The event word stays set until that block pulses a clear strobe. A separate configuration word sits beside the frame register. Its two transceiver-select bits are read-only.

Top module: `mii_mgmt_interp`

## Requirements
- R1: The frame word is decoded with these field positions:
  - start field in bits 31:30
  - opcode in bits 29:28
  - PHY address in bits 27:23
  - register address in bits 22:18
  - turnaround in bits 17:16
  - data in bits 15:0
- R2: Every frame write is stored so that `frame_q` shows bit 16 set on the first cycle after the write. `frame_q` does not change on cycles without a frame write.
- R3: A frame whose start field is not 01, or whose PHY address differs from `PHY_ADDR` (default 1), is stored as written with bit 16 set. No PHY register changes.
- R4: A valid frame with opcode 01 stores its data field into the addressed register. The stored frame equals the written word with bit 16 set.
- R5: A valid frame with opcode 10 is stored with bits 31:17 unchanged, bit 16 set, and bits 15:0 replaced by the addressed register's contents.
- R6: A write to register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R7: A write to register 0 with bit 9 set has these effects:
  - register 0 is stored with bit 9 cleared;
  - bit 5 of register 1 is set;
  - if the link is up, bit 2 of register 1 and bit 8 of register 5 are also set.
- R8: Reset leaves the registers in this state:
  - register 4 = 0x0100;
  - register 1 = 0x4028, or 0x402C when the link is up;
  - register 5 = 0x0100 when the link is up, else 0;
  - registers 2 and 3 = `ID_HI` / `ID_LO`;
  - all other registers = 0;
  - `frame_q` = 0 and `evt_q` = 0.
- R9: A change of `link_up` sets bit 2 of register 1 and bit 8 of register 5 to the new link level. It also sets `evt_q` to 0xFFFF, visible on the next cycle.
- R10: A pulse on `evt_clr` clears `evt_q` to 0. A simultaneous link change wins.
- R11: The config word resets to 0x00000100. A config write stores all bits except 9:8, which keep their previous values.
- R12: A valid frame with opcode 00 or 11 changes no register and is stored with bit 16 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the frame or config word |
| wr_sel | input | 1 | 0 selects the frame word, 1 the config word |
| wr_data | input | 32 | Word being written |
| link_up | input | 1 | Link level from the line side |
| evt_clr | input | 1 | Clears the management event word |
| frame_q | output | 32 | Stored frame word with completion and read data |
| cfg_q | output | 32 | Stored config word |
| evt_q | output | 16 | Management event word for the interrupt block |

## Verification
A corrupted PHY register can only be seen through a later read frame. Each register is therefore read back on the cycle after the frame that should have changed it. A stuck or mis-merged side-effect bit shows at the ports within two frame writes. A wrong field decode or a missed rejection shows on the very next `frame_q` value, either as changed data or as a register that moved when it should not have. A lost link event appears in `evt_q` one cycle after the link edge. The bits of registers 1 and 5 that follow the link are read in the cycles after it.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
   localparam int FRAME_W  = 32;
   localparam int ADDR_W   = 5;
   localparam int DATA_W   = 16;

   // field positions inside the frame word (software-visible)
   localparam int ST_LSB   = 30;
   localparam int OP_LSB   = 28;
   localparam int PA_LSB   = 23;
   localparam int RA_LSB   = 18;
   localparam int DONE_BIT = 16;

   typedef enum logic [1:0] {
      OPC_NONE = 2'b00,
      OPC_WR   = 2'b01,
      OPC_RD   = 2'b10,
      OPC_RSV  = 2'b11
   } opc_e;

   typedef struct packed {
      logic              valid;
      opc_e              op;
      logic [ADDR_W-1:0] ra;
      logic [DATA_W-1:0] data;
   } mgmt_cmd_t;

   // register indices
   localparam int REG_CTL  = 0;
   localparam int REG_STS  = 1;
   localparam int REG_ID_H = 2;
   localparam int REG_ID_L = 3;
   localparam int REG_ADV  = 4;
   localparam int REG_LPA  = 5;

   // bit positions
   localparam int CTL_RST     = 15;
   localparam int CTL_AN_EN   = 12;
   localparam int CTL_AN_RST  = 9;
   localparam int STS_LINK    = 2;
   localparam int STS_AN_DONE = 5;
   localparam int LPA_TXFD    = 8;

   localparam logic [15:0] STS_BASE = 16'h4028;
   localparam logic [15:0] ADV_BASE = 16'h0100;
endpackage

// File: rtl/mgmt_frame_dec.sv
module mgmt_frame_dec
   import mgmt_pkg::*;
#(
   parameter int PHY_ADDR = 1
) (
   input  logic [FRAME_W-1:0] frame,
   output mgmt_cmd_t          cmd
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PHY_ADDR);

   initial begin
      if (PHY_ADDR < 0 || PHY_ADDR >= (1 << ADDR_W))
         $error("PHY_ADDR out of range");
   end

   logic start_ok, addr_ok;

   always_comb begin
      start_ok  = frame[ST_LSB +: 2] == 2'b01;
      addr_ok   = frame[PA_LSB +: ADDR_W] == MY_ADDR;
      cmd.valid = start_ok && addr_ok;
      cmd.op    = opc_e'(frame[OP_LSB +: 2]);
      cmd.ra    = frame[RA_LSB +: ADDR_W];
      cmd.data  = frame[DATA_W-1:0];
   end
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
   import mgmt_pkg::*;
#(
   parameter int          NREG  = 32,
   parameter logic [15:0] ID_HI = 16'h2000,
   parameter logic [15:0] ID_LO = 16'h5C01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              link_chg
);
   localparam int IDX_W = $clog2(NREG);

   initial begin
      if (NREG != (1 << ADDR_W)) $error("NREG must match register address width");
      if (IDX_W != ADDR_W)       $error("index width mismatch");
   end

   logic              link_q;
   logic [DATA_W-1:0] rf [NREG];
   logic [DATA_W-1:0] wval;
   logic              restart_hit;

   // control-register self-clearing bits applied before storage
   always_comb begin
      wval = wr_data;
      if (wr_idx == ADDR_W'(REG_CTL)) begin
         if (wval[CTL_RST]) begin
            wval[CTL_RST]   = 1'b0;
            wval[CTL_AN_EN] = 1'b1;
         end
         wval[CTL_AN_RST] = 1'b0;
      end
   end

   assign restart_hit = wr_en && (wr_idx == ADDR_W'(REG_CTL)) && wr_data[CTL_AN_RST];
   assign link_chg    = link_up != link_q;

   always_ff @(posedge clk) begin
      if (!rst_n) link_q <= link_up;
      else        link_q <= link_up;
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DATA_W-1:0] r_q, r_nxt, r_rst;

      always_comb begin
         case (i)
            REG_STS:  r_rst = STS_BASE | (DATA_W'(link_up) << STS_LINK);
            REG_ID_H: r_rst = ID_HI;
            REG_ID_L: r_rst = ID_LO;
            REG_ADV:  r_rst = ADV_BASE;
            REG_LPA:  r_rst = DATA_W'(link_up) << LPA_TXFD;
            default:  r_rst = '0;
         endcase
      end

      always_comb begin
         r_nxt = r_q;
         if (wr_en && wr_idx == ADDR_W'(i)) r_nxt = wval;
         if (i == REG_STS && restart_hit) begin
            r_nxt[STS_AN_DONE] = 1'b1;
            if (link_q) r_nxt[STS_LINK] = 1'b1;
         end
         if (i == REG_LPA && restart_hit && link_q) r_nxt[LPA_TXFD] = 1'b1;
         if (link_chg) begin
            if (i == REG_STS) r_nxt[STS_LINK] = link_up;
            if (i == REG_LPA) r_nxt[LPA_TXFD] = link_up;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) r_q <= r_rst;
         else        r_q <= r_nxt;
      end

      assign rf[i] = r_q;
   end

   assign rd_data = rf[rd_idx];
endmodule

// File: rtl/mii_mgmt_interp.sv
module mii_mgmt_interp
   import mgmt_pkg::*;
#(
   parameter int          PHY_ADDR = 1,
   parameter int          NREG     = 32,
   parameter logic [15:0] ID_HI    = 16'h2000,
   parameter logic [15:0] ID_LO    = 16'h5C01
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_sel,
   input  logic [31:0] wr_data,
   input  logic        link_up,
   input  logic        evt_clr,
   output logic [31:0] frame_q,
   output logic [31:0] cfg_q,
   output logic [15:0] evt_q
);
   localparam logic [31:0] CFG_RST = 32'h0000_0100;
   localparam logic [31:0] CFG_RO  = 32'h0000_0300;

   mgmt_cmd_t         cmd;
   logic              frame_wr, reg_wr, link_chg;
   logic [DATA_W-1:0] rd_data;
   logic [31:0]       frame_nxt;

   mgmt_frame_dec #(.PHY_ADDR(PHY_ADDR)) u_dec (
      .frame (wr_data),
      .cmd   (cmd)
   );

   assign frame_wr = wr_en && !wr_sel;
   assign reg_wr   = frame_wr && cmd.valid && cmd.op == OPC_WR;

   mgmt_phy_regs #(.NREG(NREG), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .link_up  (link_up),
      .wr_en    (reg_wr),
      .wr_idx   (cmd.ra),
      .wr_data  (cmd.data),
      .rd_idx   (cmd.ra),
      .rd_data  (rd_data),
      .link_chg (link_chg)
   );

   always_comb begin
      frame_nxt           = wr_data;
      frame_nxt[DONE_BIT] = 1'b1;
      if (cmd.valid && cmd.op == OPC_RD) frame_nxt[DATA_W-1:0] = rd_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
         cfg_q   <= CFG_RST;
         evt_q   <= '0;
      end else begin
         if (frame_wr) frame_q <= frame_nxt;
         if (wr_en && wr_sel) cfg_q <= (wr_data & ~CFG_RO) | (cfg_q & CFG_RO);
         if (link_chg)     evt_q <= '1;
         else if (evt_clr) evt_q <= '0;
      end
   end
endmodule

// File: rtl/mgmt_interp_chk.sv
module mgmt_interp_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_sel,
   input logic [31:0] wr_data,
   input logic        link_up,
   input logic [31:0] frame_q,
   input logic [31:0] cfg_q,
   input logic [15:0] evt_q
);
   p_done_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> frame_q[16]);

   p_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !wr_sel) |=> $stable(frame_q));

   p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && (wr_data[31:30] != 2'b01))
      |=> frame_q == ($past(wr_data) | 32'h0001_0000));

   p_cfg_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> cfg_q[9:8] == $past(cfg_q[9:8]));

   p_evt_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && link_up != $past(link_up)) |=> evt_q == 16'hFFFF);
endmodule

bind mii_mgmt_interp mgmt_interp_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .link_up (link_up),
   .frame_q (frame_q),
   .cfg_q   (cfg_q),
   .evt_q   (evt_q)
);

// File: tb/mii_mgmt_interp_bench.sv
module mii_mgmt_interp_bench;
   localparam logic [15:0] IDH = 16'h2000;
   localparam logic [15:0] IDL = 16'h5C01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        link_up = 1'b1;
   logic        evt_clr = 1'b0;
   logic [31:0] frame_q, cfg_q;
   logic [15:0] evt_q;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mii_mgmt_interp #(.ID_HI(IDH), .ID_LO(IDL)) u_mii_mgmt_interp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .link_up(link_up), .evt_clr(evt_clr),
      .frame_q(frame_q), .cfg_q(cfg_q), .evt_q(evt_q)
   );

   function automatic logic [31:0] mk(logic [1:0] st, logic [1:0] op,
                                      logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
      return {st, op, pa, ra, 2'b00, d};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic sel, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_reg(logic [4:0] ra, output logic [15:0] v);
      wr(1'b0, mk(2'b01, 2'b10, 5'd1, ra, 16'h0000));
      v = frame_q[15:0];
   endtask

   task automatic wr_reg(logic [4:0] ra, logic [15:0] d);
      wr(1'b0, mk(2'b01, 2'b01, 5'd1, ra, d));
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk("R8 frame", frame_q, 32'h0);
      chk("R11 cfg reset", cfg_q, 32'h100);
      chk("R8 evt", {16'h0, evt_q}, 32'h0);
      rd_reg(5'd1, v); chk("R8 reg1", {16'h0, v}, 32'h402C);
      rd_reg(5'd4, v); chk("R8 reg4", {16'h0, v}, 32'h0100);
      rd_reg(5'd5, v); chk("R8 reg5", {16'h0, v}, 32'h0100);
      rd_reg(5'd2, v); chk("R8 reg2", {16'h0, v}, {16'h0, IDH});
      rd_reg(5'd3, v); chk("R8 reg3", {16'h0, v}, {16'h0, IDL});
      rd_reg(5'd0, v); chk("R8 reg0", {16'h0, v}, 32'h0);
      rd_reg(5'd30, v); chk("R8 reg30", {16'h0, v}, 32'h0);
   endtask

   task automatic t_rw;
      logic [15:0] v;
      logic [31:0] f;
      f = mk(2'b01, 2'b01, 5'd1, 5'd17, 16'hA5C3);
      wr(1'b0, f);
      chk("R4 write frame", frame_q, f | 32'h1_0000);
      f = mk(2'b01, 2'b10, 5'd1, 5'd17, 16'hDEAD);
      wr(1'b0, f);
      chk("R5 read frame R1", frame_q, {f[31:17], 1'b1, 16'hA5C3});
      rd_reg(5'd17, v); chk("R2 done bit", {31'h0, frame_q[16]}, 32'h1);
   endtask

   task automatic t_reject;
      logic [15:0] v;
      logic [31:0] f;
      f = mk(2'b11, 2'b01, 5'd1, 5'd17, 16'h1111);
      wr(1'b0, f);
      chk("R3 bad start frame", frame_q, f | 32'h1_0000);
      rd_reg(5'd17, v); chk("R3 bad start no write", {16'h0, v}, 32'hA5C3);
      f = mk(2'b01, 2'b01, 5'd2, 5'd17, 16'h2222);
      wr(1'b0, f);
      chk("R3 wrong phy frame", frame_q, f | 32'h1_0000);
      rd_reg(5'd17, v); chk("R3 wrong phy no write", {16'h0, v}, 32'hA5C3);
      f = mk(2'b01, 2'b10, 5'd0, 5'd17, 16'h3333);
      wr(1'b0, f);
      chk("R3 wrong phy read keeps data", frame_q, f | 32'h1_0000);
      f = mk(2'b01, 2'b00, 5'd1, 5'd17, 16'h4444);
      wr(1'b0, f);
      chk("R12 op00 frame", frame_q, f | 32'h1_0000);
      f = mk(2'b01, 2'b11, 5'd1, 5'd17, 16'h5555);
      wr(1'b0, f);
      chk("R12 op11 frame", frame_q, f | 32'h1_0000);
      rd_reg(5'd17, v); chk("R12 no write", {16'h0, v}, 32'hA5C3);
   endtask

   task automatic t_ctl_reset;
      logic [15:0] v;
      wr_reg(5'd0, 16'h8000);
      rd_reg(5'd0, v); chk("R6 reset bit", {16'h0, v}, 32'h1000);
      wr_reg(5'd0, 16'h0000);
      rd_reg(5'd0, v); chk("R4 ctl plain", {16'h0, v}, 32'h0);
   endtask

   task automatic t_link_restart;
      logic [15:0] v;
      @(negedge clk); link_up = 1'b0;
      @(negedge clk);
      chk("R9 evt on down", {16'h0, evt_q}, 32'hFFFF);
      rd_reg(5'd1, v); chk("R9 reg1 down", {16'h0, v}, 32'h4028);
      rd_reg(5'd5, v); chk("R9 reg5 down", {16'h0, v}, 32'h0);
      @(negedge clk); evt_clr = 1'b1;
      @(negedge clk); evt_clr = 1'b0;
      chk("R10 evt clear", {16'h0, evt_q}, 32'h0);
      wr_reg(5'd1, 16'h0000);
      wr_reg(5'd0, 16'h0200);
      rd_reg(5'd0, v); chk("R7 restart self clear", {16'h0, v}, 32'h0);
      rd_reg(5'd1, v); chk("R7 an done link down", {16'h0, v}, 32'h0020);
      rd_reg(5'd5, v); chk("R7 lpa link down", {16'h0, v}, 32'h0);
      @(negedge clk); link_up = 1'b1;
      @(negedge clk);
      chk("R9 evt on up", {16'h0, evt_q}, 32'hFFFF);
      rd_reg(5'd1, v); chk("R9 reg1 up", {16'h0, v}, 32'h0024);
      rd_reg(5'd5, v); chk("R9 reg5 up", {16'h0, v}, 32'h0100);
      @(negedge clk); evt_clr = 1'b1;
      @(negedge clk); evt_clr = 1'b0;
      wr_reg(5'd1, 16'h0000);
      wr_reg(5'd5, 16'h0000);
      wr_reg(5'd0, 16'h8200);
      rd_reg(5'd0, v); chk("R7 R6 combined ctl", {16'h0, v}, 32'h1000);
      rd_reg(5'd1, v); chk("R7 reg1 link up", {16'h0, v}, 32'h0024);
      rd_reg(5'd5, v); chk("R7 reg5 link up", {16'h0, v}, 32'h0100);
      chk("R10 evt stays clear", {16'h0, evt_q}, 32'h0);
   endtask

   task automatic t_cfg;
      wr(1'b1, 32'hFFFF_FCFF);
      chk("R11 cfg ro keep", cfg_q, 32'hFFFF_FDFF);
      wr(1'b1, 32'h0000_0200);
      chk("R11 cfg ro ignore", cfg_q, 32'h0000_0100);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rw();
      t_reject();
      t_ctl_reset();
      t_link_restart();
      t_cfg();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule